// File: doc/BRIEF.md
# Crosspoint Reset and Configuration Controller

This block owns the per-output configuration state of a small crosspoint switch (8 inputs by 8 outputs by default) and decides when that state returns to its defaults. Four kinds of reset reach it: a power-on reset, an active-low hardware reset pin, a JTAG reset, and a device-reset command on a 4-bit instruction port. The JTAG reset can come from the TRST pin or from five TCK rising edges in a row with TMS high. A second instruction on the same port clears only the connection map and leaves the output modes alone.

Each output has four configuration fields: an input-select field, a registered/flow-through bit, a clock-select bit and an output-enable bit. A plain write port loads these fields so that software-visible settings exist for the resets to act on. A small TAP state tracker follows TMS on TCK edges so that test-logic-reset can be detected and forced. The asynchronous pins and TCK/TMS pass through two-flop synchronisers into the single system clock domain. A status output names the reset source that acted most recently.

Top module: `xrc_ctrl`

## Requirements
- R1: Every device reset sets each output to flow-through (`out_regd`=0), global clock (`out_lclk`=0) and enabled (`out_oe`=1), and puts the TAP state at test-logic-reset, encoded 4'hF.
- R2: While `hw_rst_n` is held low, all outputs take the R1 defaults and every select field becomes the no-connection code N_IN (8 by default), no later than the third rising clock edge after the fall. `last_src` then reads 2.
- R3: While `trst_n` is held low, the outputs take the R1 defaults, the select fields keep their values, and `last_src` reads 3.
- R4: Five consecutive TCK rising edges with TMS high trigger a device reset that keeps the select fields, and `last_src` reads 4. The count restarts when TMS is sampled low on a TCK edge, and it saturates at five, so a longer run of TMS-high edges triggers only once.
- R5: `instr` = 4'b1101 with `instr_vld` high at a clock edge applies the R1 defaults on that edge and keeps the select fields. `last_src` reads 5.
- R6: `instr` = 4'b0010 with `instr_vld` high sets every select field to N_IN on that edge. It leaves the mode bits and the TAP state unchanged, and `last_src` reads 6.
- R7: Any other instruction code, or any code with `instr_vld` low, changes no output.
- R8: With no reset active, `cfg_we` writes `cfg_sel`, `cfg_regd`, `cfg_lclk` and `cfg_oe` into output `cfg_port` at the next edge. Any reset active in that cycle discards the write. An array clear in the same cycle overrides the written select field.
- R9: While `por` is high and after its release, all outputs hold the R1 defaults with every select field at N_IN, and `last_src` reads 1.
- R10: The TAP state follows the standard 16-state TMS transitions on each TCK rising edge. The encodings are: test-logic-reset F, run-idle C, select-DR 7, capture-DR 6, shift-DR 2, exit1-DR 1, pause-DR 3, exit2-DR 0, update-DR 5, select-IR 4, capture-IR E, shift-IR A, exit1-IR 9, pause-IR B, exit2-IR 8, update-IR D.
- R11: When sources coincide, `last_src` takes the highest priority among them: power-on, hardware, TRST, TMS run, device command, array clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| trst_n | input | 1 | JTAG TAP reset, active low, asynchronous |
| tck | input | 1 | JTAG test clock, sampled in the clk domain |
| tms | input | 1 | JTAG mode select |
| instr_vld | input | 1 | Qualifies `instr` on a clock edge |
| instr | input | 4 | Configuration instruction code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | $clog2(N_OUT) | Output index to write |
| cfg_sel | input | $clog2(N_IN+1) | Input select to write |
| cfg_regd | input | 1 | Registered-mode bit to write |
| cfg_lclk | input | 1 | Local-clock select bit to write |
| cfg_oe | input | 1 | Output-enable bit to write |
| out_sel | output | N_OUT*$clog2(N_IN+1) | Select field per output, output i at bits i*W |
| out_regd | output | N_OUT | Registered-mode bit per output |
| out_lclk | output | N_OUT | Local-clock select bit per output |
| out_oe | output | N_OUT | Output-enable bit per output |
| tap_state | output | 4 | TAP tracker state |
| last_src | output | 3 | Most recent reset source: 0 none, 1 power-on, 2 hardware, 3 TRST, 4 TMS run, 5 device command, 6 array clear |

## Verification
A wrong internal state shows up directly on the per-output fields, which are registered. A misdecoded instruction or a bad reset scope is therefore visible on the first edge after the stimulus: a select field is kept when it should be cleared, or cleared when it should be kept. A TMS counter that fails to restart or saturate shows up either as a device reset after a broken TMS run, or as none after a full run. Both appear on the mode bits and `last_src` within one TCK period. A wrong TAP transition shows on `tap_state` after the edge that caused it.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

  typedef enum logic [3:0] {
    TAP_EX2DR   = 4'h0, TAP_EX1DR  = 4'h1, TAP_SHDR   = 4'h2, TAP_PAUSEDR = 4'h3,
    TAP_SELIR   = 4'h4, TAP_UPDDR  = 4'h5, TAP_CAPDR  = 4'h6, TAP_SELDR   = 4'h7,
    TAP_EX2IR   = 4'h8, TAP_EX1IR  = 4'h9, TAP_SHIR   = 4'hA, TAP_PAUSEIR = 4'hB,
    TAP_RTI     = 4'hC, TAP_UPDIR  = 4'hD, TAP_CAPIR  = 4'hE, TAP_TLR     = 4'hF
  } tap_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_POR = 3'd1, SRC_HW = 3'd2, SRC_TRST = 3'd3,
    SRC_TMS  = 3'd4, SRC_CMD = 3'd5, SRC_ARR = 3'd6
  } src_e;

  localparam logic [3:0] OP_DEV_RST = 4'b1101;
  localparam logic [3:0] OP_ARR_CLR = 4'b0010;

endpackage

// File: rtl/xrc_sync.sv
module xrc_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xrc_tap.sv
module xrc_tap
  import xrc_pkg::*;
#(
  parameter int HOLD = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic force_tlr,
  input  logic tck_rise,
  input  logic tms,
  output tap_e state,
  output logic tms_run_evt
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] CMAX = CW'(HOLD);

  logic [CW-1:0] cnt;
  tap_e nxt;

  always_comb begin
    unique case (state)
      TAP_TLR:     nxt = tms ? TAP_TLR   : TAP_RTI;
      TAP_RTI:     nxt = tms ? TAP_SELDR : TAP_RTI;
      TAP_SELDR:   nxt = tms ? TAP_SELIR : TAP_CAPDR;
      TAP_CAPDR:   nxt = tms ? TAP_EX1DR : TAP_SHDR;
      TAP_SHDR:    nxt = tms ? TAP_EX1DR : TAP_SHDR;
      TAP_EX1DR:   nxt = tms ? TAP_UPDDR : TAP_PAUSEDR;
      TAP_PAUSEDR: nxt = tms ? TAP_EX2DR : TAP_PAUSEDR;
      TAP_EX2DR:   nxt = tms ? TAP_UPDDR : TAP_SHDR;
      TAP_UPDDR:   nxt = tms ? TAP_SELDR : TAP_RTI;
      TAP_SELIR:   nxt = tms ? TAP_TLR   : TAP_CAPIR;
      TAP_CAPIR:   nxt = tms ? TAP_EX1IR : TAP_SHIR;
      TAP_SHIR:    nxt = tms ? TAP_EX1IR : TAP_SHIR;
      TAP_EX1IR:   nxt = tms ? TAP_UPDIR : TAP_PAUSEIR;
      TAP_PAUSEIR: nxt = tms ? TAP_EX2IR : TAP_PAUSEIR;
      TAP_EX2IR:   nxt = tms ? TAP_UPDIR : TAP_SHIR;
      TAP_UPDIR:   nxt = tms ? TAP_SELDR : TAP_RTI;
      default:     nxt = TAP_TLR;
    endcase
  end

  // the run event fires once, on the edge that moves the count to HOLD
  assign tms_run_evt = tck_rise && tms && (cnt == CMAX - 1'b1) && !force_tlr;

  always_ff @(posedge clk) begin
    if (rst || force_tlr) begin
      state <= TAP_TLR;
      cnt   <= '0;
    end else if (tck_rise) begin
      if (!tms)             cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
      state <= tms_run_evt ? TAP_TLR : nxt;
    end
  end

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst) cnt <= CMAX);
  p_run_tlr_r4: assert property (@(posedge clk) disable iff (rst)
    tms_run_evt |=> (state == TAP_TLR) && (cnt == CMAX));
  p_force_tlr_r1: assert property (@(posedge clk) disable iff (rst)
    force_tlr |=> (state == TAP_TLR) && (cnt == '0));
  p_low_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (tck_rise && !tms && !force_tlr) |=> (cnt == '0));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!tck_rise && !force_tlr) |=> $stable(state));
endmodule

// File: rtl/xrc_portcfg.sv
module xrc_portcfg #(
  parameter int SW = 4,
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_full,
  input  logic          rst_mode,
  input  logic          clr_arr,
  input  logic          we,
  input  logic [SW-1:0] w_sel,
  input  logic          w_regd,
  input  logic          w_lclk,
  input  logic          w_oe,
  output logic [SW-1:0] sel,
  output logic          regd,
  output logic          lclk,
  output logic          oe
);
  localparam logic [SW-1:0] SEL_NC = SW'(NC);

  always_ff @(posedge clk) begin
    if (rst_full) begin
      sel  <= SEL_NC;
      regd <= 1'b0;
      lclk <= 1'b0;
      oe   <= 1'b1;
    end else if (rst_mode) begin
      regd <= 1'b0;
      lclk <= 1'b0;
      oe   <= 1'b1;
    end else begin
      if (we) begin
        sel  <= w_sel;
        regd <= w_regd;
        lclk <= w_lclk;
        oe   <= w_oe;
      end
      if (clr_arr) sel <= SEL_NC;
    end
  end

  p_clr_nc_r6: assert property (@(posedge clk) disable iff (rst_full)
    (clr_arr && !rst_mode) |=> (sel == SEL_NC));
  p_clr_keeps_mode_r6: assert property (@(posedge clk) disable iff (rst_full)
    (clr_arr && !we && !rst_mode) |=> $stable(regd) && $stable(lclk) && $stable(oe));
  p_mode_rst_keeps_sel_r3: assert property (@(posedge clk) disable iff (rst_full)
    rst_mode |=> $stable(sel) && !regd && !lclk && oe);
endmodule

// File: rtl/xrc_ctrl.sv
module xrc_ctrl
  import xrc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int HOLD  = 5,
  parameter int SW    = $clog2(N_IN + 1),
  parameter int PW    = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                clk,
  input  logic                por,
  input  logic                hw_rst_n,
  input  logic                trst_n,
  input  logic                tck,
  input  logic                tms,
  input  logic                instr_vld,
  input  logic [3:0]          instr,
  input  logic                cfg_we,
  input  logic [PW-1:0]       cfg_port,
  input  logic [SW-1:0]       cfg_sel,
  input  logic                cfg_regd,
  input  logic                cfg_lclk,
  input  logic                cfg_oe,
  output logic [N_OUT*SW-1:0] out_sel,
  output logic [N_OUT-1:0]    out_regd,
  output logic [N_OUT-1:0]    out_lclk,
  output logic [N_OUT-1:0]    out_oe,
  output logic [3:0]          tap_state,
  output logic [2:0]          last_src
);
  logic hw_s, trst_s, tck_s, tms_s, tck_d;
  logic hw_req, trst_req, tck_rise;
  logic cmd_rst, arr_clr, tms_evt;
  logic rst_full, rst_mode, any_rst;
  tap_e tap_q;
  src_e src_q;

  xrc_sync #(.STAGES(2), .INIT(1'b1)) u_sync_hw   (.clk(clk), .rst(por), .d(hw_rst_n), .q(hw_s));
  xrc_sync #(.STAGES(2), .INIT(1'b1)) u_sync_trst (.clk(clk), .rst(por), .d(trst_n),   .q(trst_s));
  xrc_sync #(.STAGES(2), .INIT(1'b0)) u_sync_tck  (.clk(clk), .rst(por), .d(tck),      .q(tck_s));
  xrc_sync #(.STAGES(2), .INIT(1'b1)) u_sync_tms  (.clk(clk), .rst(por), .d(tms),      .q(tms_s));

  always_ff @(posedge clk) begin
    if (por) tck_d <= 1'b0;
    else     tck_d <= tck_s;
  end

  assign tck_rise = tck_s && !tck_d;
  assign hw_req   = !hw_s;
  assign trst_req = !trst_s;
  assign cmd_rst  = instr_vld && (instr == OP_DEV_RST);
  assign arr_clr  = instr_vld && (instr == OP_ARR_CLR);
  assign rst_full = por || hw_req;
  assign rst_mode = trst_req || tms_evt || cmd_rst;
  assign any_rst  = rst_full || rst_mode;

  xrc_tap #(.HOLD(HOLD)) u_tap (
    .clk        (clk),
    .rst        (por),
    .force_tlr  (hw_req || trst_req || cmd_rst),
    .tck_rise   (tck_rise),
    .tms        (tms_s),
    .state      (tap_q),
    .tms_run_evt(tms_evt)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_port
    xrc_portcfg #(.SW(SW), .NC(N_IN)) u_cfg (
      .clk     (clk),
      .rst_full(rst_full),
      .rst_mode(rst_mode),
      .clr_arr (arr_clr && !any_rst),
      .we      (cfg_we && !any_rst && (cfg_port == PW'(i))),
      .w_sel   (cfg_sel),
      .w_regd  (cfg_regd),
      .w_lclk  (cfg_lclk),
      .w_oe    (cfg_oe),
      .sel     (out_sel[i*SW +: SW]),
      .regd    (out_regd[i]),
      .lclk    (out_lclk[i]),
      .oe      (out_oe[i])
    );
  end

  // priority order of the status register follows R11
  always_ff @(posedge clk) begin
    if (por)           src_q <= SRC_POR;
    else if (hw_req)   src_q <= SRC_HW;
    else if (trst_req) src_q <= SRC_TRST;
    else if (tms_evt)  src_q <= SRC_TMS;
    else if (cmd_rst)  src_q <= SRC_CMD;
    else if (arr_clr)  src_q <= SRC_ARR;
  end

  assign tap_state = tap_q;
  assign last_src  = src_q;

  p_hw_full_r2: assert property (@(posedge clk) disable iff (por)
    hw_req |=> (out_oe == '1) && (out_regd == '0) && (out_lclk == '0)
               && (last_src == SRC_HW) && (tap_state == TAP_TLR));
  p_trst_tlr_r3: assert property (@(posedge clk) disable iff (por)
    (trst_req && !hw_req) |=> (tap_state == TAP_TLR) && (last_src == SRC_TRST));
  p_cmd_defaults_r5: assert property (@(posedge clk) disable iff (por)
    (cmd_rst && !hw_req) |=> (out_oe == '1) && (out_regd == '0) && $stable(out_sel));
  p_other_code_r7: assert property (@(posedge clk) disable iff (por)
    (instr_vld && !cmd_rst && !arr_clr && !cfg_we && !any_rst)
      |=> $stable(out_sel) && $stable(out_regd) && $stable(out_lclk)
          && $stable(out_oe) && $stable(last_src));
  p_prio_hw_cmd_r11: assert property (@(posedge clk) disable iff (por)
    (hw_req && instr_vld) |=> (last_src == SRC_HW));
endmodule

// File: tb/tb_xrc_ctrl.sv
`timescale 1ns/1ps
module tb_xrc_ctrl;
  localparam int N_IN  = 8;
  localparam int N_OUT = 8;
  localparam int SW    = $clog2(N_IN + 1);
  localparam int PW    = $clog2(N_OUT);
  localparam logic [SW-1:0] NC = SW'(N_IN);

  logic clk = 1'b0;
  logic por = 1'b1, hw_rst_n = 1'b1, trst_n = 1'b1, tck = 1'b0, tms = 1'b1;
  logic instr_vld = 1'b0, cfg_we = 1'b0, cfg_regd = 1'b0, cfg_lclk = 1'b0, cfg_oe = 1'b0;
  logic [3:0] instr = 4'h0;
  logic [PW-1:0] cfg_port = '0;
  logic [SW-1:0] cfg_sel = '0;
  logic [N_OUT*SW-1:0] out_sel;
  logic [N_OUT-1:0] out_regd, out_lclk, out_oe;
  logic [3:0] tap_state;
  logic [2:0] last_src;

  always #2.5 clk = ~clk;

  xrc_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT)) dut (
    .clk(clk), .por(por), .hw_rst_n(hw_rst_n), .trst_n(trst_n), .tck(tck), .tms(tms),
    .instr_vld(instr_vld), .instr(instr), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_sel(cfg_sel), .cfg_regd(cfg_regd), .cfg_lclk(cfg_lclk), .cfg_oe(cfg_oe),
    .out_sel(out_sel), .out_regd(out_regd), .out_lclk(out_lclk), .out_oe(out_oe),
    .tap_state(tap_state), .last_src(last_src));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [SW-1:0]    e_sel [N_OUT];
  logic [N_OUT-1:0] e_regd, e_lclk, e_oe;
  logic [3:0]       e_tap;
  logic [2:0]       e_last;
  int               e_cnt;

  function automatic logic [3:0] tap_next(logic [3:0] s, logic m);
    case (s)
      4'hF: return m ? 4'hF : 4'hC;
      4'hC: return m ? 4'h7 : 4'hC;
      4'h7: return m ? 4'h4 : 4'h6;
      4'h6: return m ? 4'h1 : 4'h2;
      4'h2: return m ? 4'h1 : 4'h2;
      4'h1: return m ? 4'h5 : 4'h3;
      4'h3: return m ? 4'h0 : 4'h3;
      4'h0: return m ? 4'h5 : 4'h2;
      4'h5: return m ? 4'h7 : 4'hC;
      4'h4: return m ? 4'hF : 4'hE;
      4'hE: return m ? 4'h9 : 4'hA;
      4'hA: return m ? 4'h9 : 4'hA;
      4'h9: return m ? 4'hD : 4'hB;
      4'hB: return m ? 4'h8 : 4'hB;
      4'h8: return m ? 4'hD : 4'hA;
      default: return m ? 4'h7 : 4'hC;
    endcase
  endfunction

  task automatic m_mode(logic [2:0] src);
    e_regd = '0; e_lclk = '0; e_oe = '1; e_tap = 4'hF; e_cnt = 0; e_last = src;
  endtask

  task automatic m_full(logic [2:0] src);
    m_mode(src);
    for (int i = 0; i < N_OUT; i++) e_sel[i] = NC;
  endtask

  task automatic check_outs(string req);
    logic [N_OUT*SW-1:0] xs;
    for (int i = 0; i < N_OUT; i++) xs[i*SW +: SW] = e_sel[i];
    checks++;
    if (out_sel !== xs || out_regd !== e_regd || out_lclk !== e_lclk || out_oe !== e_oe ||
        tap_state !== e_tap || last_src !== e_last) begin
      errors++;
      $display("FAIL %s actual sel=%h regd=%b lclk=%b oe=%b tap=%h src=%0d expected sel=%h regd=%b lclk=%b oe=%b tap=%h src=%0d",
               req, out_sel, out_regd, out_lclk, out_oe, tap_state, last_src,
               xs, e_regd, e_lclk, e_oe, e_tap, e_last);
    end
  endtask

  // one clock with the currently driven synchronous inputs, model update, check at negedge
  task automatic sync_cycle(string req, bit do_check);
    @(posedge clk);
    if (instr_vld && instr == 4'b1101) m_mode(3'd5);
    else begin
      if (cfg_we) begin
        e_sel[cfg_port] = cfg_sel; e_regd[cfg_port] = cfg_regd;
        e_lclk[cfg_port] = cfg_lclk; e_oe[cfg_port] = cfg_oe;
      end
      if (instr_vld && instr == 4'b0010) begin
        for (int i = 0; i < N_OUT; i++) e_sel[i] = NC;
        e_last = 3'd6;
      end
    end
    @(negedge clk);
    if (do_check) check_outs(req);
    cfg_we = 1'b0; instr_vld = 1'b0;
  endtask

  task automatic load_cfg();
    for (int p = 0; p < N_OUT; p++) begin
      cfg_we = 1'b1; cfg_port = PW'(p); cfg_sel = SW'($urandom_range(0, N_IN - 1));
      cfg_regd = 1'b1; cfg_lclk = 1'b1; cfg_oe = 1'b0;
      sync_cycle("R8", 1'b0);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tck_pulse(logic v, string req);
    tms = v; tck = 1'b0;
    idle(4);
    tck = 1'b1;
    idle(4);
    if (v && e_cnt == 4) begin
      m_mode(3'd4); e_cnt = 5;
    end else begin
      e_cnt = v ? ((e_cnt == 5) ? 5 : e_cnt + 1) : 0;
      e_tap = tap_next(e_tap, v);
    end
    check_outs(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_full(3'd1);
    // R9 power-on held for six cycles
    idle(6);
    check_outs("R9 R1 during power-on");
    por = 1'b0;
    idle(3);
    check_outs("R9 R1 after power-on release");

    // random synchronous traffic: writes, device command, array clear, other codes
    for (int k = 0; k < 400; k++) begin
      int r;
      string req;
      r = $urandom_range(0, 15);
      cfg_we = ($urandom_range(0, 3) != 0);
      cfg_port = PW'($urandom_range(0, N_OUT - 1));
      cfg_sel = SW'($urandom_range(0, N_IN));
      cfg_regd = 1'($urandom); cfg_lclk = 1'($urandom); cfg_oe = 1'($urandom);
      instr_vld = 1'b0; req = "R8 write";
      if (r == 0) begin instr_vld = 1'b1; instr = 4'b1101; req = "R5 device command"; end
      else if (r == 1) begin instr_vld = 1'b1; instr = 4'b0010; req = "R6 array clear"; end
      else if (r < 6) begin
        instr_vld = 1'b1;
        do instr = 4'($urandom); while (instr == 4'b1101 || instr == 4'b0010);
        req = "R7 other code";
      end else if (r < 8) begin
        instr = ($urandom_range(0, 1) != 0) ? 4'b1101 : 4'b0010;
        req = "R7 strobe low";
      end
      sync_cycle(req, 1'b1);
    end

    // R7 directed: every non-reset code with no write
    load_cfg();
    for (int c = 0; c < 16; c++) begin
      if (c == 13 || c == 2) continue;
      instr_vld = 1'b1; instr = 4'(c);
      sync_cycle("R7 directed code", 1'b1);
    end

    // R2 hardware reset
    load_cfg();
    hw_rst_n = 1'b0;
    idle(3);
    m_full(3'd2);
    check_outs("R2 R1 hardware reset third edge");
    idle(2);
    hw_rst_n = 1'b1;
    idle(4);
    check_outs("R2 after release");

    // R3 TRST reset keeps the array
    load_cfg();
    trst_n = 1'b0;
    idle(4);
    m_mode(3'd3);
    check_outs("R3 R1 trst reset");
    trst_n = 1'b1;
    idle(4);

    // R10 directed TAP walk from test-logic-reset
    load_cfg();
    tck_pulse(1'b0, "R10 to run-idle");
    tck_pulse(1'b1, "R10 to select-DR");
    tck_pulse(1'b0, "R10 to capture-DR");
    tck_pulse(1'b0, "R10 to shift-DR");
    tck_pulse(1'b1, "R10 to exit1-DR");
    tck_pulse(1'b0, "R10 to pause-DR");
    tck_pulse(1'b1, "R10 to exit2-DR");
    tck_pulse(1'b1, "R10 to update-DR");
    tck_pulse(1'b1, "R10 to select-DR again");
    tck_pulse(1'b1, "R10 to select-IR");
    tck_pulse(1'b0, "R10 to capture-IR");

    // R4 broken runs do not reset, a full run resets once
    load_cfg();
    for (int j = 0; j < 4; j++) tck_pulse(1'b1, "R4 partial run");
    tck_pulse(1'b0, "R4 counter restart");
    for (int j = 0; j < 4; j++) tck_pulse(1'b1, "R4 partial run after restart");
    tck_pulse(1'b1, "R4 fifth high edge resets");
    load_cfg();
    tck_pulse(1'b1, "R4 saturated, no second reset");
    tck_pulse(1'b1, "R4 saturated, no second reset");

    // R10 random TMS sequences with the model
    tck_pulse(1'b0, "R10 leave reset");
    for (int j = 0; j < 60; j++) tck_pulse(1'($urandom_range(0, 2) != 0), "R10 R4 random TMS");

    // R11 hardware and device command together
    load_cfg();
    hw_rst_n = 1'b0;
    idle(3);
    instr_vld = 1'b1; instr = 4'b1101;
    idle(1);
    instr_vld = 1'b0;
    idle(1);
    m_full(3'd2);
    check_outs("R11 hardware outranks command");
    hw_rst_n = 1'b1;
    idle(4);

    // R11 command and clear cannot coincide; TRST with command
    trst_n = 1'b0;
    idle(3);
    instr_vld = 1'b1; instr = 4'b1101;
    idle(1);
    instr_vld = 1'b0;
    m_mode(3'd3);
    check_outs("R11 trst outranks command");
    trst_n = 1'b1;
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule